// File: doc/BRIEF.md
# Slave Status Register Logic

This block forms the four-bit status word a bus slave returns when the master issues a read-status request. Bit 0 reports whether the slave address currently lives only in volatile storage or whether the non-volatile memory is busy writing. Bit 1 reports an external periphery fault or a parity failure in either protected memory region. Bit 2 is unused and reads zero. Bit 3 reports that the non-volatile memory contents are corrupted.

The address-delete indication in bit 0 is sticky. A delete request sets it only when the address held before the delete was nonzero. It stays set until a new nonzero address has been committed to memory, which the block sees as the end of a write while the address is nonzero. The active-low periphery fault input is asynchronous, so it passes through a synchronizer first. The composed word is latched into an output register on each read-status strobe, which keeps the answer steady while the serial side sends it.

Top module: `slave_status_word`

## Requirements
- R1: A cycle with `del_addr_stb`=1 and `slave_addr`!=0 sets the sticky delete flag, so S0 reads 1 afterwards. A delete with `slave_addr`=0 leaves the flag unchanged.
- R2: When `ee_wr_busy` is 1 in the capture cycle, S0 (`status_q[0]`) is 1.
- R3: S0 is 0 when the sticky flag is clear and `ee_wr_busy` is 0.
- R4: S1 (`status_q[1]`) is 1 when `fw_parity_err` or `safety_parity_err` is 1 in the capture cycle.
- R5: `periph_fault_n` reaches S1 through a two-flop synchronizer. A level held on the input for at least two rising edges before the capture edge sets S1 when it is low.
- R6: S2 (`status_q[2]`) always reads 0.
- R7: S3 (`status_q[3]`) equals `ee_corrupt` in the capture cycle.
- R8: A falling edge of `ee_wr_busy` while `slave_addr`!=0 clears the sticky flag, with no delete in the same cycle, since a set wins. A write that ends while the address is 0 does not clear it.
- R9: `status_q` loads the composed word only on a rising edge with `rdst_stb`=1. At all other edges it holds its value.
- R10: After reset, `status_q` is 0000, the sticky flag is clear and the synchronizer reports no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| del_addr_stb | input | 1 | One-cycle address-delete request strobe |
| slave_addr | input | ADDR_W | Current slave address |
| ee_wr_busy | input | 1 | Non-volatile memory write in progress |
| periph_fault_n | input | 1 | Asynchronous periphery fault, active low |
| fw_parity_err | input | 1 | Parity error in the firmware memory region |
| safety_parity_err | input | 1 | Parity error in the safety memory region |
| ee_corrupt | input | 1 | Memory contents corrupted |
| rdst_stb | input | 1 | Read-status request strobe; captures the word |
| status_q | output | 4 | Captured status word, bit n = Sn |

## Verification
The bench builds the block with its default values: a 5-bit address and a two-stage synchronizer. The 5-bit address is small enough for the bench to sweep every address through a delete-then-clear cycle. That covers the zero-address exclusion on both setting and clearing the sticky flag. The bench also drives all 32 combinations of busy, fault, the two parity flags and corruption into a capture. With two synchronizer stages, the fault latency is a fixed two edges, so the bench can place its captures exactly.

// File: rtl/slave_status_pkg.sv
package slave_status_pkg;

  localparam int STATUS_W = 4;
  localparam int S0_POS = 0;
  localparam int S1_POS = 1;
  localparam int S2_POS = 2;
  localparam int S3_POS = 3;

  typedef logic [STATUS_W-1:0] status_word_t;

  // Assemble the status word from its independent causes.
  function automatic status_word_t compose_status(
    input logic del_sticky,
    input logic wr_busy,
    input logic fault_ok,
    input logic fw_perr,
    input logic sf_perr,
    input logic corrupt
  );
    status_word_t w;
    w         = '0;
    w[S0_POS] = del_sticky | wr_busy;
    w[S1_POS] = ~fault_ok | fw_perr | sf_perr;
    w[S2_POS] = 1'b0;
    w[S3_POS] = corrupt;
    return w;
  endfunction

endpackage

// File: rtl/status_sync.sv
module status_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/s0_tracker.sv
module s0_tracker #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              del_stb,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              wr_busy,
  output logic              sticky
);

  logic busy_d;
  logic addr_nz;
  logic write_done;
  logic set_evt;
  logic clr_evt;

  assign addr_nz    = |slave_addr;
  assign write_done = busy_d & ~wr_busy;
  assign set_evt    = del_stb & addr_nz;
  assign clr_evt    = write_done & addr_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_d <= 1'b0;
      sticky <= 1'b0;
    end else begin
      busy_d <= wr_busy;
      if (set_evt)      sticky <= 1'b1;
      else if (clr_evt) sticky <= 1'b0;
    end
  end

  assert_del_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> sticky);

  assert_zero_del_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sticky && !set_evt) |=> !sticky);

  assert_write_end_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !sticky);

endmodule

// File: rtl/status_capture.sv
module status_capture
  import slave_status_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_stb,
  input  status_word_t word_in,
  output status_word_t word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (cap_stb) word_q <= word_in;
  end

  assert_hold_without_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(word_q));

endmodule

// File: rtl/slave_status_word.sv
module slave_status_word
  import slave_status_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              del_addr_stb,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              ee_wr_busy,
  input  logic              periph_fault_n,
  input  logic              fw_parity_err,
  input  logic              safety_parity_err,
  input  logic              ee_corrupt,
  input  logic              rdst_stb,
  output logic [3:0]        status_q
);

  logic         fault_ok_sync;
  logic         del_sticky;
  status_word_t live_word;
  status_word_t cap_word;

  status_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_fault_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (periph_fault_n),
    .q     (fault_ok_sync)
  );

  s0_tracker #(.ADDR_W(ADDR_W)) u_s0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .del_stb    (del_addr_stb),
    .slave_addr (slave_addr),
    .wr_busy    (ee_wr_busy),
    .sticky     (del_sticky)
  );

  assign live_word = compose_status(del_sticky, ee_wr_busy, fault_ok_sync,
                                    fw_parity_err, safety_parity_err, ee_corrupt);

  status_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_stb (rdst_stb),
    .word_in (live_word),
    .word_q  (cap_word)
  );

  assign status_q = cap_word;

  assert_busy_forces_s0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdst_stb && ee_wr_busy) |=> status_q[S0_POS]);

  assert_parity_sets_s1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdst_stb && (fw_parity_err || safety_parity_err)) |=> status_q[S1_POS]);

  assert_s2_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdst_stb |=> !status_q[S2_POS]);

  assert_corrupt_to_s3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdst_stb |=> (status_q[S3_POS] == $past(ee_corrupt)));

endmodule

// File: tb/slave_status_word_bench.sv
`timescale 1ns/1ps
module slave_status_word_bench;

  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              del_addr_stb = 1'b0;
  logic [ADDR_W-1:0] slave_addr = '0;
  logic              ee_wr_busy = 1'b0;
  logic              periph_fault_n = 1'b1;
  logic              fw_parity_err = 1'b0;
  logic              safety_parity_err = 1'b0;
  logic              ee_corrupt = 1'b0;
  logic              rdst_stb = 1'b0;
  logic [3:0]        status_q;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slave_status_word #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_slave_status_word (
    .clk(clk), .rst_n(rst_n), .del_addr_stb(del_addr_stb), .slave_addr(slave_addr),
    .ee_wr_busy(ee_wr_busy), .periph_fault_n(periph_fault_n),
    .fw_parity_err(fw_parity_err), .safety_parity_err(safety_parity_err),
    .ee_corrupt(ee_corrupt), .rdst_stb(rdst_stb), .status_q(status_q)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: status actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [3:0] v);
    @(negedge clk); rdst_stb = 1'b1;
    @(posedge clk); #1; v = status_q;
    @(negedge clk); rdst_stb = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic pulse_delete(input logic [ADDR_W-1:0] a);
    @(negedge clk); slave_addr = a; del_addr_stb = 1'b1;
    @(negedge clk); del_addr_stb = 1'b0; slave_addr = '0;
  endtask

  task automatic write_cycle(input logic [ADDR_W-1:0] a);
    @(negedge clk); slave_addr = a; ee_wr_busy = 1'b1;
    @(negedge clk); @(negedge clk); ee_wr_busy = 1'b0;
    @(negedge clk);
  endtask

  // Expected word, built bit by bit from the requirements.
  function automatic logic [3:0] expect_word(input bit stk, input bit bsy, input bit fn,
                                             input bit fw, input bit sf, input bit cor);
    logic [3:0] e;
    e[0] = stk || bsy;
    e[1] = (fn == 1'b0) || fw || sf;
    e[2] = 1'b0;
    e[3] = cor;
    return e;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    repeat (3) @(posedge clk);
    #1; check("R10 reset value", status_q, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    do_read(v); check("R10 no fault after reset", v, 4'b0000);

    // Exhaustive sweep of the combinational causes with the sticky flag clear
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ee_wr_busy = i[0]; periph_fault_n = i[1]; fw_parity_err = i[2];
      safety_parity_err = i[3]; ee_corrupt = i[4];
      settle();
      do_read(v);
      check("R2 R3 R4 R5 R6 R7 sweep", v,
            expect_word(1'b0, i[0], i[1], i[2], i[3], i[4]));
    end
    @(negedge clk);
    ee_wr_busy = 0; periph_fault_n = 1; fw_parity_err = 0; safety_parity_err = 0; ee_corrupt = 0;
    settle();

    // R5: the fault is not visible after only one edge
    @(negedge clk); periph_fault_n = 1'b0; rdst_stb = 1'b1;
    @(posedge clk); #1; check("R5 one edge too early", status_q, 4'b0000);
    @(posedge clk); #1; check("R5 still in synchronizer", status_q, 4'b0000);
    @(posedge clk); #1; check("R5 visible after two edges", status_q, 4'b0010);
    @(negedge clk); rdst_stb = 1'b0; periph_fault_n = 1'b1;
    settle();

    // R9: without a read strobe the register holds
    do_read(v);
    @(negedge clk); ee_corrupt = 1'b1; ee_wr_busy = 1'b1;
    repeat (5) @(posedge clk);
    #1; check("R9 hold without read", status_q, 4'b0000);
    do_read(v); check("R9 update on read", v, 4'b1001);
    @(negedge clk); ee_corrupt = 1'b0; ee_wr_busy = 1'b0;

    // R1/R8: sweep every address through a delete and a clearing write
    for (int a = 0; a < 32; a++) begin
      pulse_delete(a[ADDR_W-1:0]);
      do_read(v);
      check("R1 delete sets only for nonzero address", v, {3'b000, (a != 0)});
      write_cycle('0);
      do_read(v);
      check("R8 write at address zero keeps flag", v, {3'b000, (a != 0)});
      write_cycle(5'd1 + a[ADDR_W-1:0] % 5'd31);
      @(negedge clk); slave_addr = '0;
      do_read(v);
      check("R8 write at nonzero address clears flag", v, 4'b0000);
    end

    // R8: simultaneous delete and write end; set wins
    @(negedge clk); slave_addr = 5'd9; ee_wr_busy = 1'b1;
    @(negedge clk); ee_wr_busy = 1'b0; del_addr_stb = 1'b1;
    @(negedge clk); del_addr_stb = 1'b0; slave_addr = '0;
    do_read(v); check("R8 set wins over clear", v, 4'b0001);
    write_cycle(5'd3);
    do_read(v); check("R3 cleared again", v, 4'b0000);

    // R10: reset clears the sticky flag
    pulse_delete(5'd17);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_read(v); check("R10 reset clears sticky flag", v, 4'b0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule